// File: doc/BRIEF.md
# Trigger Throttle Buffer Occupancy Tracker

This block keeps a local copy of how many event buffers are filled inside a remote front-end readout chip, so that the trigger source can be held off before the chip runs out of storage. It sees the same single-cycle trigger and chip-reset pulses that the remote chip receives, plus a pulse each time the chip starts sending one stored event. From these it keeps an up/down count of occupied buffers, bounded between zero and the buffer depth (ten by default).

The count is compared against two programmable levels that arrive on input ports. The lower level drives a warning and the higher level drives busy. Both are registered from the next count, so they change on the same clock edge as the count. Four external fast-feedback inputs (ready, busy, warn, out-of-sync) come from further down the feedback chain. Each is ORed into the internal signal of the same kind, so the trigger system sees a single merged set. Two sticky flags report a trigger that arrived with no free buffer and a frame pulse that arrived with no buffer occupied.

Top module: `trig_throttle`

## Requirements
- R1: A trigger pulse without a frame pulse raises `fill_o` by one, and a frame pulse without a trigger lowers it by one. The new value appears after the next rising clock edge.
- R2: `fill_o` never goes above DEPTH (10) nor below 0. A trigger at DEPTH leaves it at DEPTH, and a frame pulse at 0 leaves it at 0.
- R3: A trigger and a frame pulse in the same cycle leave `fill_o` unchanged.
- R4: One cycle after any inputs, `busy_o` is 1 exactly when the updated count is greater than or equal to the `busy_lvl_i` value of the prior cycle, or when `ext_busy_i` was 1 in that cycle.
- R5: One cycle after any inputs, `warn_o` is 1 exactly when the updated count is greater than or equal to the prior `warn_lvl_i`, or when `ext_warn_i` was 1.
- R6: One cycle after any inputs, `ready_o` is 1 exactly when the updated count is below the prior `busy_lvl_i`, or when `ext_ready_i` was 1.
- R7: `oos_o` equals the value `ext_oos_i` had one cycle earlier. The block has no internal out-of-sync source.
- R8: A trigger without a frame pulse while `fill_o` is DEPTH sets `ovf_o`. It then stays at 1 until `clr_i` or `rst`.
- R9: A frame pulse without a trigger while `fill_o` is 0 sets `unf_o`. It then stays at 1 until `clr_i` or `rst`.
- R10: `clr_i` overrides triggers and frame pulses in the same cycle. One cycle later `fill_o` is 0 and both sticky flags are 0.
- R11: While `rst` is high, every output is 0 on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| trig_i | input | 1 | Trigger pulse, one buffer filled |
| frame_i | input | 1 | Frame-output pulse, one buffer freed |
| clr_i | input | 1 | Chip reset pulse, all buffers emptied |
| warn_lvl_i | input | CNT_W (4) | Warning level |
| busy_lvl_i | input | CNT_W (4) | Busy level |
| ext_ready_i | input | 1 | External ready feedback |
| ext_busy_i | input | 1 | External busy feedback |
| ext_warn_i | input | 1 | External warning feedback |
| ext_oos_i | input | 1 | External out-of-sync feedback |
| fill_o | output | CNT_W (4) | Occupied buffer count |
| warn_o | output | 1 | Merged warning |
| busy_o | output | 1 | Merged busy |
| ready_o | output | 1 | Merged ready |
| oos_o | output | 1 | Merged out-of-sync |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
The assertions assume that each pulse input is valid for exactly one cycle per event. They also assume that the two levels, when they change, change only at a clock edge, because the properties compare against the level value from the cycle before. The stimulus drives every input half a cycle away from the active edge. It sweeps every warn/busy level pair from 0 to 11, including levels above the depth. Within each pair it alternates trigger-heavy and frame-heavy phases, so the count reaches both bounds and both sticky flags get set. Chip-reset pulses and external feedback come from a deterministic shift register, so the overriding cases are exercised in many count states.

// File: rtl/occ_pkg.sv
package occ_pkg;
  localparam int FB_READY = 0;
  localparam int FB_BUSY  = 1;
  localparam int FB_WARN  = 2;
  localparam int FB_OOS   = 3;
  localparam int FB_N     = 4;
endpackage

// File: rtl/occ_counter.sv
module occ_counter #(
  parameter int DEPTH = 10,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             ovf_q, ovf_n, unf_q, unf_n;

  always_comb begin
    cnt_n = cnt_q;
    ovf_n = ovf_q;
    unf_n = unf_q;
    if (clr_i) begin
      cnt_n = '0;
      ovf_n = 1'b0;
      unf_n = 1'b0;
    end else begin
      case ({up_i, dn_i})
        2'b10: begin
          if (cnt_q == FULL) ovf_n = 1'b1;
          else               cnt_n = cnt_q + 1'b1;
        end
        2'b01: begin
          if (cnt_q == '0) unf_n = 1'b1;
          else             cnt_n = cnt_q - 1'b1;
        end
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      ovf_q <= ovf_n;
      unf_q <= unf_n;
    end
  end

  assign cnt_next_o = cnt_n;
  assign cnt_o      = cnt_q;
  assign ovf_o      = ovf_q;
  assign unf_o      = unf_q;
endmodule

// File: rtl/occ_level_cmp.sv
module occ_level_cmp #(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] level_i,
  output logic             reached_o
);
  always_comb reached_o = (cnt_i >= level_i);
endmodule

// File: rtl/occ_fb_merge.sv
module occ_fb_merge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] int_i,
  input  logic [N-1:0] ext_i,
  output logic [N-1:0] out_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= int_i[g] | ext_i[g];
    end
    assign out_o[g] = q;
  end
endmodule

// File: rtl/trig_throttle.sv
module trig_throttle
  import occ_pkg::*;
#(
  parameter int DEPTH = 10,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_i,
  input  logic             frame_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] warn_lvl_i,
  input  logic [CNT_W-1:0] busy_lvl_i,
  input  logic             ext_ready_i,
  input  logic             ext_busy_i,
  input  logic             ext_warn_i,
  input  logic             ext_oos_i,
  output logic [CNT_W-1:0] fill_o,
  output logic             warn_o,
  output logic             busy_o,
  output logic             ready_o,
  output logic             oos_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam int NLVL = 2;
  localparam int L_WARN = 0;
  localparam int L_BUSY = 1;

  logic [CNT_W-1:0] cnt_next;
  logic [CNT_W-1:0] lvl [NLVL];
  logic [NLVL-1:0]  hit;
  logic [FB_N-1:0]  int_fb, ext_fb, out_fb;

  occ_counter #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .up_i       (trig_i),
    .dn_i       (frame_i),
    .clr_i      (clr_i),
    .cnt_next_o (cnt_next),
    .cnt_o      (fill_o),
    .ovf_o      (ovf_o),
    .unf_o      (unf_o)
  );

  assign lvl[L_WARN] = warn_lvl_i;
  assign lvl[L_BUSY] = busy_lvl_i;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    occ_level_cmp #(.CNT_W(CNT_W)) u_cmp (
      .cnt_i     (cnt_next),
      .level_i   (lvl[g]),
      .reached_o (hit[g])
    );
  end

  always_comb begin
    int_fb           = '0;
    int_fb[FB_READY] = ~hit[L_BUSY];
    int_fb[FB_BUSY]  = hit[L_BUSY];
    int_fb[FB_WARN]  = hit[L_WARN];
    int_fb[FB_OOS]   = 1'b0;
    ext_fb           = '0;
    ext_fb[FB_READY] = ext_ready_i;
    ext_fb[FB_BUSY]  = ext_busy_i;
    ext_fb[FB_WARN]  = ext_warn_i;
    ext_fb[FB_OOS]   = ext_oos_i;
  end

  occ_fb_merge #(.N(FB_N)) u_merge (
    .clk   (clk),
    .rst   (rst),
    .int_i (int_fb),
    .ext_i (ext_fb),
    .out_o (out_fb)
  );

  assign ready_o = out_fb[FB_READY];
  assign busy_o  = out_fb[FB_BUSY];
  assign warn_o  = out_fb[FB_WARN];
  assign oos_o   = out_fb[FB_OOS];
endmodule

// File: rtl/occ_checker.sv
module occ_checker #(
  parameter int DEPTH = 10,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             trig_i,
  input logic             frame_i,
  input logic             clr_i,
  input logic [CNT_W-1:0] warn_lvl_i,
  input logic [CNT_W-1:0] busy_lvl_i,
  input logic             ext_ready_i,
  input logic             ext_busy_i,
  input logic             ext_warn_i,
  input logic             ext_oos_i,
  input logic [CNT_W-1:0] fill_o,
  input logic             warn_o,
  input logic             busy_o,
  input logic             ready_o,
  input logic             oos_o,
  input logic             ovf_o,
  input logic             unf_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  AST_FILL_RANGE: assert property (@(posedge clk) disable iff (rst)
    fill_o <= FULL); // R2
  AST_TRIG_UP: assert property (@(posedge clk) disable iff (rst)
    (trig_i && !frame_i && !clr_i && fill_o != FULL) |=> fill_o == $past(fill_o) + 1'b1); // R1
  AST_FRAME_DOWN: assert property (@(posedge clk) disable iff (rst)
    (frame_i && !trig_i && !clr_i && fill_o != '0) |=> fill_o == $past(fill_o) - 1'b1); // R1
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (trig_i && frame_i && !clr_i) |=> $stable(fill_o)); // R3
  AST_BUSY_MERGE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> busy_o == ((fill_o >= $past(busy_lvl_i)) || $past(ext_busy_i))); // R4
  AST_WARN_MERGE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> warn_o == ((fill_o >= $past(warn_lvl_i)) || $past(ext_warn_i))); // R5
  AST_READY_MERGE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ready_o == ((fill_o < $past(busy_lvl_i)) || $past(ext_ready_i))); // R6
  AST_OOS_PASS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> oos_o == $past(ext_oos_i)); // R7
  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    (trig_i && !frame_i && !clr_i && fill_o == FULL) |=> ovf_o); // R8
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !clr_i) |=> ovf_o); // R8
  AST_UNF_SET: assert property (@(posedge clk) disable iff (rst)
    (frame_i && !trig_i && !clr_i && fill_o == '0) |=> unf_o); // R9
  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (unf_o && !clr_i) |=> unf_o); // R9
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (fill_o == '0 && !ovf_o && !unf_o)); // R10
  AST_RST_ZERO: assert property (@(posedge clk)
    rst |=> (fill_o == '0 && !warn_o && !busy_o && !ready_o && !oos_o && !ovf_o && !unf_o)); // R11
endmodule

bind trig_throttle occ_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ_checker (
  .clk(clk), .rst(rst), .trig_i(trig_i), .frame_i(frame_i), .clr_i(clr_i),
  .warn_lvl_i(warn_lvl_i), .busy_lvl_i(busy_lvl_i),
  .ext_ready_i(ext_ready_i), .ext_busy_i(ext_busy_i),
  .ext_warn_i(ext_warn_i), .ext_oos_i(ext_oos_i),
  .fill_o(fill_o), .warn_o(warn_o), .busy_o(busy_o), .ready_o(ready_o),
  .oos_o(oos_o), .ovf_o(ovf_o), .unf_o(unf_o)
);

// File: tb/test_trig_throttle.sv
module test_trig_throttle;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 10;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int WDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 1'b0, frame = 1'b0, clr = 1'b0;
  logic [CNT_W-1:0] wlvl = '0, blvl = '0;
  logic e_rdy = 1'b0, e_bsy = 1'b0, e_wrn = 1'b0, e_oos = 1'b0;
  logic [CNT_W-1:0] fill;
  logic warn, busy, ready, oos, ovf, unf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_cnt = 0;
  bit m_ovf = 1'b0, m_unf = 1'b0;
  logic [15:0] lf = 16'hACE1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  trig_throttle #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_trig_throttle (
    .clk(clk), .rst(rst), .trig_i(trig), .frame_i(frame), .clr_i(clr),
    .warn_lvl_i(wlvl), .busy_lvl_i(blvl),
    .ext_ready_i(e_rdy), .ext_busy_i(e_bsy), .ext_warn_i(e_wrn), .ext_oos_i(e_oos),
    .fill_o(fill), .warn_o(warn), .busy_o(busy), .ready_o(ready),
    .oos_o(oos), .ovf_o(ovf), .unf_o(unf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle of inputs, update model at the edge, compare half a cycle later
  task automatic step(input bit t, input bit f, input bit c,
                      input bit er, input bit eb, input bit ew, input bit eo);
    string ftag;
    bit exp_b, exp_w, exp_r;
    trig = t; frame = f; clr = c;
    e_rdy = er; e_bsy = eb; e_wrn = ew; e_oos = eo;
    ftag = "R1";
    if (c) begin
      m_cnt = 0; m_ovf = 1'b0; m_unf = 1'b0; ftag = "R10";
    end else if (t && !f) begin
      if (m_cnt == DEPTH) begin m_ovf = 1'b1; ftag = "R2"; end
      else m_cnt++;
    end else if (f && !t) begin
      if (m_cnt == 0) begin m_unf = 1'b1; ftag = "R2"; end
      else m_cnt--;
    end else if (t && f) ftag = "R3";
    exp_b = (m_cnt >= int'(blvl)) || eb;
    exp_w = (m_cnt >= int'(wlvl)) || ew;
    exp_r = (m_cnt < int'(blvl)) || er;
    @(posedge clk);
    @(negedge clk);
    chk(ftag, int'(fill), m_cnt);
    chk("R4 busy", int'(busy), int'(exp_b));
    chk("R5 warn", int'(warn), int'(exp_w));
    chk("R6 ready", int'(ready), int'(exp_r));
    chk("R7 oos", int'(oos), int'(eo));
    chk(c ? "R10 ovf" : "R8 ovf", int'(ovf), int'(m_ovf));
    chk(c ? "R10 unf" : "R9 unf", int'(unf), int'(m_unf));
  endtask

  task automatic adv();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic check_reset_state();
    chk("R11 fill", int'(fill), 0);
    chk("R11 busy", int'(busy), 0);
    chk("R11 warn", int'(warn), 0);
    chk("R11 ready", int'(ready), 0);
    chk("R11 oos", int'(oos), 0);
    chk("R11 ovf", int'(ovf), 0);
    chk("R11 unf", int'(unf), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;

    // directed: fill to the top, overflow, both pulses, drain, underflow
    wlvl = CNT_W'(5); blvl = CNT_W'(8);
    for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < DEPTH + 2; i++) step(0, 1, 0, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0, 0);  // R10 clear beats trigger
    step(0, 0, 0, 1, 1, 1, 1);  // external feedback alone

    // sweep every level pair with biased pseudo-random traffic
    for (int b = 0; b <= DEPTH + 1; b++) begin
      for (int w = 0; w <= DEPTH + 1; w++) begin
        wlvl = CNT_W'(w); blvl = CNT_W'(b);
        step(0, 0, 1, 0, 0, 0, 0);
        for (int k = 0; k < 40; k++) begin
          bit heavy_up;
          heavy_up = (k < 20);
          adv();
          step(heavy_up ? (lf[0] | lf[1]) : (lf[0] & lf[1]),
               heavy_up ? (lf[2] & lf[3]) : (lf[2] | lf[3]),
               lf[4] & lf[5] & lf[6] & lf[7] & lf[8],
               lf[9] & lf[10] & lf[11],
               lf[12] & lf[13] & lf[9],
               lf[14] & lf[15] & lf[11],
               lf[1] & lf[6] & lf[13]);
        end
      end
    end

    // block reset with activity pending
    wlvl = CNT_W'(1); blvl = CNT_W'(2);
    for (int i = 0; i < DEPTH + 1; i++) step(1, 0, 0, 1, 1, 1, 1);
    rst = 1'b1; trig = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_reset_state();
    rst = 1'b0; trig = 1'b0;
    m_cnt = 0; m_ovf = 1'b0; m_unf = 1'b0;
    step(0, 0, 0, 0, 0, 0, 0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule